// File: doc/BRIEF.md
# Framed Byte Command to Register Bus Bridge

This block turns a stream of received bytes into single register accesses on a simple internal bus and answers each command with a framed reply. A host sends a frame one byte at a time. The frame carries an operation code, a 16-bit address and, for a write, a 32-bit value. The bridge checks the frame, performs one bus access (or pulses a reset line toward the attached cores), and then sends a reply byte by byte through a valid/ready output.

Every reply is framed. It carries a status code, the echoed address and any read data, with the most significant byte first. Malformed or unrecognised frames get a short reply that carries the offending operation byte, and they never touch the bus. The block handles one command at a time. Until a reply has been fully handed over, every incoming byte is dropped.

Top module: `cmdbus_bridge`

## Requirements
- R1: While no frame is open, any received byte other than 0x55 is discarded: it causes no bus access, no reset pulse and no reply.
- R2: The frame 0x55, 0x10, A1, A0, 0xAA produces exactly one bus cycle with chip-select high, write-enable low and address {A1, A0} (A1 in bits 15:8).
- R3: A completed read is answered with 0xAA, 0x7F, A1, A0, then the four read-data bytes most significant first, then 0x55. The data is the bus read value sampled in the cycle after chip-select.
- R4: The frame 0x55, 0x11, A1, A0, D3, D2, D1, D0, 0xAA produces exactly one bus cycle with chip-select and write-enable high, address {A1, A0} and write data {D3, D2, D1, D0}.
- R5: A completed write is answered with 0xAA, 0x7E, A1, A0, 0x55.
- R6: The frame 0x55, 0x01, 0xAA raises the core reset output for exactly one cycle, with no bus access, and is answered with 0xAA, 0x7D, 0x55.
- R7: If the byte in the end position of a read, write or reset frame is not 0xAA, no bus access or reset pulse occurs, and the reply is 0xAA, 0xFD, the operation byte, 0x55.
- R8: For an operation byte other than 0x01, 0x10 or 0x11, every byte up to the next 0xAA is discarded. The reply is then 0xAA, 0xFE, the operation byte, 0x55, with no bus access.
- R9: Bytes received after a frame's end byte and before the last reply byte has been accepted are discarded and start no new command.
- R10: While a reply byte is offered and not accepted, the output stays valid and its value does not change.
- R11: Chip-select is never high in two consecutive cycles, and it is never high while a reply is being sent.
- R12: After reset, output valid, chip-select and core reset are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte | input | 8 | Received byte |
| rx_strobe | input | 1 | rx_byte valid for this cycle |
| tx_byte | output | 8 | Reply byte |
| tx_valid | output | 1 | tx_byte is offered |
| tx_ready | input | 1 | Receiver takes tx_byte this cycle |
| core_rst | output | 1 | One-cycle reset pulse to the attached cores |
| bus_cs | output | 1 | Bus chip-select |
| bus_we | output | 1 | Bus write-enable |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data, sampled the cycle after chip-select |

## Verification
The hardest case to reach from the ports is a complete new frame that arrives while a reply is still waiting in the output. The bench forces this by holding tx_ready low and waiting for the first reply byte. It then sends a full write frame, releases the output and checks three things: exactly one reply appears, no second bus cycle happens, and a later read shows the target register unchanged. The random phase mixes good, truncated and unknown frames with random output back-pressure.

// File: rtl/cmdbus_pkg.sv
// Shared constants and types for the byte-command bridge.
// Assumes byte-wide framing; all codes are 8 bits.
package cmdbus_pkg;

    localparam logic [7:0] CMD_SOF    = 8'h55;
    localparam logic [7:0] CMD_EOF    = 8'hAA;
    localparam logic [7:0] RSP_SOF    = 8'hAA;
    localparam logic [7:0] RSP_EOF    = 8'h55;
    localparam logic [7:0] OP_READ    = 8'h10;
    localparam logic [7:0] OP_WRITE   = 8'h11;
    localparam logic [7:0] OP_RESET   = 8'h01;
    localparam logic [7:0] ST_RD_OK   = 8'h7F;
    localparam logic [7:0] ST_WR_OK   = 8'h7E;
    localparam logic [7:0] ST_RST_OK  = 8'h7D;
    localparam logic [7:0] ST_UNKNOWN = 8'hFE;
    localparam logic [7:0] ST_ERROR   = 8'hFD;

    typedef enum logic [3:0] {
        PS_IDLE, PS_OPCODE, PS_ADDR, PS_DATA, PS_END, PS_SKIP,
        PS_ACCESS, PS_SAMPLE, PS_REPLY, PS_WAIT
    } parse_state_t;

    typedef enum logic [1:0] {
        RK_READ, RK_WRITE, RK_RESET, RK_CODE
    } reply_kind_t;

endpackage

// File: rtl/cmdbus_parser.sv
// Frame parser and bus sequencer.
// Consumes one byte per strobe, checks the frame layout, performs one bus
// cycle or reset pulse, then hands a reply request to the serializer and
// waits for it to finish. Assumes bus read data is valid one cycle after
// chip-select.
module cmdbus_parser
    import cmdbus_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_strobe,
    output logic              bus_cs,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              core_rst,
    output logic              reply_load,
    output reply_kind_t       reply_kind,
    output logic [BYTE_W-1:0] reply_code,
    output logic [BYTE_W-1:0] reply_cmd,
    output logic [ADDR_W-1:0] reply_addr,
    output logic [DATA_W-1:0] reply_data,
    input  logic              reply_done
);

    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int DATA_BYTES = DATA_W / BYTE_W;
    localparam int CNT_W      = $clog2(ADDR_BYTES + DATA_BYTES + 1);

    parse_state_t      state_q;
    logic [BYTE_W-1:0] cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  cnt_q;
    reply_kind_t       kind_q;
    logic [BYTE_W-1:0] code_q;

    // Frame walk, bus sequencing and reply hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            cmd_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            cnt_q   <= '0;
            kind_q  <= RK_CODE;
            code_q  <= '0;
        end else begin
            case (state_q)
                PS_IDLE: if (rx_strobe && rx_byte == CMD_SOF) state_q <= PS_OPCODE;
                PS_OPCODE: if (rx_strobe) begin
                    cmd_q <= rx_byte;
                    cnt_q <= '0;
                    if (rx_byte == OP_READ || rx_byte == OP_WRITE) state_q <= PS_ADDR;
                    else if (rx_byte == OP_RESET)                   state_q <= PS_END;
                    else                                            state_q <= PS_SKIP;
                end
                PS_ADDR: if (rx_strobe) begin
                    addr_q <= {addr_q[ADDR_W-BYTE_W-1:0], rx_byte};
                    cnt_q  <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(ADDR_BYTES - 1)) begin
                        cnt_q   <= '0;
                        state_q <= (cmd_q == OP_WRITE) ? PS_DATA : PS_END;
                    end
                end
                PS_DATA: if (rx_strobe) begin
                    data_q <= {data_q[DATA_W-BYTE_W-1:0], rx_byte};
                    cnt_q  <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(DATA_BYTES - 1)) state_q <= PS_END;
                end
                PS_END: if (rx_strobe) begin
                    if (rx_byte == CMD_EOF) begin
                        state_q <= PS_ACCESS;
                    end else begin
                        kind_q  <= RK_CODE;
                        code_q  <= ST_ERROR;
                        state_q <= PS_REPLY;
                    end
                end
                PS_SKIP: if (rx_strobe && rx_byte == CMD_EOF) begin
                    kind_q  <= RK_CODE;
                    code_q  <= ST_UNKNOWN;
                    state_q <= PS_REPLY;
                end
                PS_ACCESS: begin
                    if (cmd_q == OP_READ) begin
                        state_q <= PS_SAMPLE;
                    end else if (cmd_q == OP_WRITE) begin
                        kind_q  <= RK_WRITE;
                        code_q  <= ST_WR_OK;
                        state_q <= PS_REPLY;
                    end else begin
                        kind_q  <= RK_RESET;
                        code_q  <= ST_RST_OK;
                        state_q <= PS_REPLY;
                    end
                end
                PS_SAMPLE: begin
                    data_q  <= bus_rdata;
                    kind_q  <= RK_READ;
                    code_q  <= ST_RD_OK;
                    state_q <= PS_REPLY;
                end
                PS_REPLY: state_q <= PS_WAIT;
                PS_WAIT:  if (reply_done) state_q <= PS_IDLE;
                default:  state_q <= PS_IDLE;
            endcase
        end
    end

    // Bus strobes and reply request derived from the current step.
    always_comb begin
        bus_cs     = (state_q == PS_ACCESS) && (cmd_q != OP_RESET);
        bus_we     = bus_cs && (cmd_q == OP_WRITE);
        core_rst   = (state_q == PS_ACCESS) && (cmd_q == OP_RESET);
        bus_addr   = addr_q;
        bus_wdata  = data_q;
        reply_load = (state_q == PS_REPLY);
        reply_kind = kind_q;
        reply_code = code_q;
        reply_cmd  = cmd_q;
        reply_addr = addr_q;
        reply_data = data_q;
    end

    // R11: a bus cycle lasts one clock.
    p_cs_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs |=> !bus_cs);

    // R6: the core reset pulse lasts one clock and never overlaps a bus cycle.
    p_rst_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> !core_rst && !bus_cs);

    // R3: read data is taken in the cycle after the read strobe.
    p_read_then_reply_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_we) |=> !reply_load ##1 reply_load);

endmodule

// File: rtl/cmdbus_reply.sv
// Reply serializer.
// Loads a reply request in one cycle, lays it out as a framed byte list and
// offers it one byte at a time on a valid/ready output. Assumes a new request
// is only loaded while idle.
module cmdbus_reply
    import cmdbus_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  reply_kind_t       kind,
    input  logic [BYTE_W-1:0] code,
    input  logic [BYTE_W-1:0] cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              done
);

    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int DATA_BYTES = DATA_W / BYTE_W;
    localparam int MAX_LEN    = 3 + ADDR_BYTES + DATA_BYTES;
    localparam int LEN_W      = $clog2(MAX_LEN + 1);

    logic [BYTE_W-1:0] frame_q [MAX_LEN];
    logic [BYTE_W-1:0] frame_d [MAX_LEN];
    logic [LEN_W-1:0]  len_q, len_d, idx_q;
    logic              busy_q;

    // Lay out the reply bytes for the requested kind.
    always_comb begin
        for (int i = 0; i < MAX_LEN; i++) frame_d[i] = '0;
        frame_d[0] = RSP_SOF;
        frame_d[1] = code;
        len_d      = LEN_W'(4);
        case (kind)
            RK_READ: begin
                for (int a = 0; a < ADDR_BYTES; a++)
                    frame_d[2 + a] = addr[ADDR_W - 1 - BYTE_W * a -: BYTE_W];
                for (int d = 0; d < DATA_BYTES; d++)
                    frame_d[2 + ADDR_BYTES + d] = data[DATA_W - 1 - BYTE_W * d -: BYTE_W];
                frame_d[MAX_LEN - 1] = RSP_EOF;
                len_d = LEN_W'(MAX_LEN);
            end
            RK_WRITE: begin
                for (int a = 0; a < ADDR_BYTES; a++)
                    frame_d[2 + a] = addr[ADDR_W - 1 - BYTE_W * a -: BYTE_W];
                frame_d[2 + ADDR_BYTES] = RSP_EOF;
                len_d = LEN_W'(3 + ADDR_BYTES);
            end
            RK_RESET: begin
                frame_d[2] = RSP_EOF;
                len_d = LEN_W'(3);
            end
            default: begin
                frame_d[2] = cmd;
                frame_d[3] = RSP_EOF;
            end
        endcase
    end

    // Hold the laid-out frame and step through it on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            len_q  <= '0;
            for (int i = 0; i < MAX_LEN; i++) frame_q[i] <= '0;
        end else if (!busy_q) begin
            if (load) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                len_q  <= len_d;
                for (int i = 0; i < MAX_LEN; i++) frame_q[i] <= frame_d[i];
            end
        end else if (tx_ready) begin
            if (idx_q == len_q - 1'b1) busy_q <= 1'b0;
            idx_q <= idx_q + 1'b1;
        end
    end

    // Present the current byte and flag the final handshake.
    always_comb begin
        tx_valid = busy_q;
        tx_byte  = frame_q[idx_q];
        done     = busy_q && tx_ready && (idx_q == len_q - 1'b1);
    end

    // R10: an offered byte stays put until it is taken.
    p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_byte));

    // R3: every reply opens with the reply start marker.
    p_reply_sof_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> tx_byte == RSP_SOF);

endmodule

// File: rtl/cmdbus_bridge.sv
// Top of the byte-command to register-bus bridge.
// Connects the frame parser to the reply serializer. Assumes the byte
// source gives at most one byte per cycle and drops nothing on its side.
module cmdbus_bridge
    import cmdbus_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_strobe,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              core_rst,
    output logic              bus_cs,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);

    logic              reply_load;
    logic              reply_done;
    reply_kind_t       reply_kind;
    logic [BYTE_W-1:0] reply_code;
    logic [BYTE_W-1:0] reply_cmd;
    logic [ADDR_W-1:0] reply_addr;
    logic [DATA_W-1:0] reply_data;

    cmdbus_parser #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) parser_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_byte    (rx_byte),
        .rx_strobe  (rx_strobe),
        .bus_cs     (bus_cs),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .core_rst   (core_rst),
        .reply_load (reply_load),
        .reply_kind (reply_kind),
        .reply_code (reply_code),
        .reply_cmd  (reply_cmd),
        .reply_addr (reply_addr),
        .reply_data (reply_data),
        .reply_done (reply_done)
    );

    cmdbus_reply #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) reply_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reply_load),
        .kind     (reply_kind),
        .code     (reply_code),
        .cmd      (reply_cmd),
        .addr     (reply_addr),
        .data     (reply_data),
        .tx_byte  (tx_byte),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .done     (reply_done)
    );

    // R11: no bus cycle while a reply is going out.
    p_no_cs_during_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !bus_cs && !core_rst);

    // R9: a reply is never reloaded while one is still in flight.
    p_no_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !reply_load);

endmodule

// File: tb/cmdbus_bridge_tb_top.sv
// Self-checking bench for cmdbus_bridge: directed corner cases followed by
// seeded random frames, with a bench register model on the bus side.
module cmdbus_bridge_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_strobe = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic        core_rst;
    logic        bus_cs;
    logic        bus_we;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    cmdbus_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_strobe(rx_strobe),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .core_rst(core_rst), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cs_cnt = 0, rst_cnt = 0, cs_run = 0, cs_run_max = 0;
    logic        last_we;
    logic [15:0] last_addr;
    logic [31:0] last_wdata;
    logic        hold_ready = 1'b0;
    logic [7:0]  cmd_b[$];
    logic [7:0]  exp_b[$];
    logic [7:0]  got_b[$];
    logic [31:0] mem[16];
    logic [31:0] shadow[16];
    logic [31:0] rdata_q = '0;

    assign bus_rdata = rdata_q;

    // Register model behind the bus; read data appears the cycle after cs.
    always @(posedge clk) begin
        if (bus_cs) begin
            if (bus_we) mem[bus_addr[3:0]] <= bus_wdata;
            else        rdata_q <= mem[bus_addr[3:0]] ^ {16'h0, bus_addr};
        end
    end

    // Output sink with random back-pressure, and bus/reset monitor.
    always @(negedge clk) begin
        tx_ready = hold_ready ? 1'b0 : ($urandom % 4 != 0);
        if (tx_valid && tx_ready) got_b.push_back(tx_byte);
        if (bus_cs) begin
            cs_cnt++;
            cs_run++;
            if (cs_run > cs_run_max) cs_run_max = cs_run;
            last_we = bus_we; last_addr = bus_addr; last_wdata = bus_wdata;
        end else cs_run = 0;
        if (core_rst) rst_cnt++;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_byte = b; rx_strobe = 1'b1;
        @(negedge clk);
        rx_strobe = 1'b0;
    endtask

    function automatic logic [31:0] read_value(input logic [15:0] a);
        return shadow[a[3:0]] ^ {16'h0, a};
    endfunction

    task automatic mk_read(input logic [15:0] a);
        logic [31:0] d = read_value(a);
        cmd_b = '{8'h55, 8'h10, a[15:8], a[7:0], 8'hAA};
        exp_b = '{8'hAA, 8'h7F, a[15:8], a[7:0], d[31:24], d[23:16], d[15:8], d[7:0], 8'h55};
    endtask

    task automatic mk_write(input logic [15:0] a, input logic [31:0] d);
        cmd_b = '{8'h55, 8'h11, a[15:8], a[7:0], d[31:24], d[23:16], d[15:8], d[7:0], 8'hAA};
        exp_b = '{8'hAA, 8'h7E, a[15:8], a[7:0], 8'h55};
        shadow[a[3:0]] = d;
    endtask

    task automatic mk_reset();
        cmd_b = '{8'h55, 8'h01, 8'hAA};
        exp_b = '{8'hAA, 8'h7D, 8'h55};
    endtask

    // Replace the end byte of a read/write/reset frame (R7).
    task automatic mk_badend(input int which, input logic [15:0] a,
                             input logic [31:0] d, input logic [7:0] endb);
        logic [7:0] op;
        case (which)
            0: op = 8'h10;
            1: op = 8'h11;
            default: op = 8'h01;
        endcase
        cmd_b = '{8'h55, op};
        if (which != 2) begin cmd_b.push_back(a[15:8]); cmd_b.push_back(a[7:0]); end
        if (which == 1) for (int k = 3; k >= 0; k--) cmd_b.push_back(d[8*k +: 8]);
        cmd_b.push_back(endb);
        exp_b = '{8'hAA, 8'hFD, op, 8'h55};
    endtask

    // Unknown opcode with a body free of the end marker (R8).
    task automatic mk_unknown(input logic [7:0] op, input int nbody);
        cmd_b = '{8'h55, op};
        for (int k = 0; k < nbody; k++) begin
            logic [7:0] b = 8'($urandom);
            if (b == 8'hAA) b = 8'h3C;
            cmd_b.push_back(b);
        end
        cmd_b.push_back(8'hAA);
        exp_b = '{8'hAA, 8'hFE, op, 8'h55};
    endtask

    task automatic run_txn(input int ecs, input int erst, input logic ewe,
                           input logic [15:0] ea, input logic [31:0] ewd,
                           input string req);
        int cs0 = cs_cnt;
        int r0 = rst_cnt;
        int w = 0;
        got_b.delete();
        foreach (cmd_b[i]) send_byte(cmd_b[i]);
        while (got_b.size() < exp_b.size() && w < 3000) begin @(negedge clk); w++; end
        repeat (20) @(negedge clk);
        check(got_b.size() == exp_b.size(), {req, " reply length"}, got_b.size(), exp_b.size());
        foreach (exp_b[i])
            if (i < got_b.size()) check(got_b[i] == exp_b[i], {req, " reply byte"}, got_b[i], exp_b[i]);
        check(cs_cnt - cs0 == ecs, {req, " bus cycles"}, cs_cnt - cs0, ecs);
        check(rst_cnt - r0 == erst, {req, " reset pulses"}, rst_cnt - r0, erst);
        if (ecs == 1 && cs_cnt - cs0 == 1) begin
            check(last_we == ewe, {req, " write-enable"}, last_we, ewe);
            check(last_addr == ea, {req, " address"}, last_addr, ea);
            if (ewe) check(last_wdata == ewd, {req, " write data"}, last_wdata, ewd);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin
            mem[i] = 32'hC0DE_0000 + 32'(i) * 32'h0101;
            shadow[i] = mem[i];
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: quiet outputs after reset.
        check(!tx_valid && !bus_cs && !core_rst, "R12", {tx_valid, bus_cs, core_rst}, 0);

        // R1: stray bytes outside a frame.
        cmd_b = '{8'hAA, 8'h10, 8'h11, 8'h01, 8'h00, 8'hFF};
        exp_b.delete();
        run_txn(0, 0, 1'b0, '0, '0, "R1");

        // R2/R3: plain read.
        mk_read(16'h0110);
        run_txn(1, 0, 1'b0, 16'h0110, '0, "R2/R3");
        // R4/R5: write then read back.
        mk_write(16'h0110, 32'hDEADBEEF);
        run_txn(1, 0, 1'b1, 16'h0110, 32'hDEADBEEF, "R4/R5");
        mk_read(16'h0110);
        run_txn(1, 0, 1'b0, 16'h0110, '0, "R3 readback");
        mk_write(16'h02FF, 32'h1337FEED);
        run_txn(1, 0, 1'b1, 16'h02FF, 32'h1337FEED, "R4 high address");
        // R6: reset request.
        mk_reset();
        run_txn(0, 1, 1'b0, '0, '0, "R6");
        // R7: bad end byte on each frame type.
        mk_badend(0, 16'h0103, '0, 8'h55);
        run_txn(0, 0, 1'b0, '0, '0, "R7 read");
        mk_badend(1, 16'h0104, 32'h01020304, 8'h00);
        run_txn(0, 0, 1'b0, '0, '0, "R7 write");
        mk_badend(2, '0, '0, 8'h7E);
        run_txn(0, 0, 1'b0, '0, '0, "R7 reset");
        mk_read(16'h0104);
        run_txn(1, 0, 1'b0, 16'h0104, '0, "R7 write dropped");
        // R8: unknown opcode with a body.
        mk_unknown(8'h42, 5);
        run_txn(0, 0, 1'b0, '0, '0, "R8");
        mk_unknown(8'h55, 0);
        run_txn(0, 0, 1'b0, '0, '0, "R8 empty body");

        // R9/R10: a whole frame arrives while the reply is held back.
        begin
            int cs0;
            int w = 0;
            logic [15:0] a2 = 16'h0107;
            logic [31:0] d2 = 32'hA5A5_5A5A;
            hold_ready = 1'b1;
            @(negedge clk);
            mk_read(16'h0105);
            got_b.delete();
            cs0 = cs_cnt;
            foreach (cmd_b[i]) send_byte(cmd_b[i]);
            while (!tx_valid && w < 100) begin @(negedge clk); w++; end
            check(tx_valid && tx_byte == 8'hAA, "R10 first byte offered", tx_byte, 8'hAA);
            repeat (3) @(negedge clk);
            check(tx_valid && tx_byte == 8'hAA, "R10 byte held", tx_byte, 8'hAA);
            cmd_b = '{8'h55, 8'h11, a2[15:8], a2[7:0], d2[31:24], d2[23:16], d2[15:8], d2[7:0], 8'hAA};
            foreach (cmd_b[i]) send_byte(cmd_b[i]);
            repeat (10) @(negedge clk);
            check(cs_cnt - cs0 == 1, "R9 no bus cycle while held", cs_cnt - cs0, 1);
            hold_ready = 1'b0;
            w = 0;
            while (got_b.size() < exp_b.size() && w < 3000) begin @(negedge clk); w++; end
            repeat (30) @(negedge clk);
            check(got_b.size() == exp_b.size(), "R9 single reply", got_b.size(), exp_b.size());
            foreach (exp_b[i])
                if (i < got_b.size()) check(got_b[i] == exp_b[i], "R9 reply byte", got_b[i], exp_b[i]);
            mk_read(a2);
            run_txn(1, 0, 1'b0, a2, '0, "R9 target unchanged");
        end

        // Random mix of all frame kinds.
        for (int n = 0; n < 60; n++) begin
            int kind = int'($urandom % 5);
            logic [15:0] a = {8'($urandom % 4), 8'($urandom)};
            logic [31:0] d = $urandom;
            case (kind)
                0: begin mk_read(a); run_txn(1, 0, 1'b0, a, '0, "R2/R3 random"); end
                1: begin mk_write(a, d); run_txn(1, 0, 1'b1, a, d, "R4/R5 random"); end
                2: begin mk_reset(); run_txn(0, 1, 1'b0, '0, '0, "R6 random"); end
                3: begin
                    logic [7:0] e = 8'($urandom);
                    if (e == 8'hAA) e = 8'h00;
                    mk_badend(int'($urandom % 3), a, d, e);
                    run_txn(0, 0, 1'b0, '0, '0, "R7 random");
                end
                default: begin
                    logic [7:0] op = 8'($urandom);
                    if (op == 8'h01 || op == 8'h10 || op == 8'h11) op = 8'h20;
                    mk_unknown(op, int'($urandom % 6));
                    run_txn(0, 0, 1'b0, '0, '0, "R8 random");
                end
            endcase
        end

        // R11: chip-select never lasted two cycles.
        check(cs_run_max <= 1, "R11", cs_run_max, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule